// File: doc/BRIEF.md
# Interrupt Signalling and Reset Gating Control Register

This block is a four-bit control register inside a board-level logic device. A host reaches it over a 16-bit bus, and only the low byte of each bus word carries data. The register sets how a set of board interrupt sources is merged onto one active-low processor interrupt line. In toggle style, each signalled event inverts the line. In pulse style, each signalled event drives the line low for a fixed 1.12 µs and then releases it. The same register also gates the board reset: it can block a board reset request before the processor enters sleep, and it can hold the memory-card reset active.

A small state machine spaces the signalling events. SIG_IDLE waits for a new source. When a new source appears, it fires. In pulse style it moves to SIG_PULSE, where the line is held low for PULSE_CYC cycles. It then moves to SIG_REARM, a hold of REARM_CYC cycles. In toggle style the line inverts and the machine goes straight to SIG_REARM. When the hold ends, the machine fires again if either of two things is true: a new source was seen while busy, or re-signalling is enabled and any source is still high. Otherwise it returns to SIG_IDLE. The default branch of the state decode leads to SIG_IDLE.

Top module: `irq_rst_ctrl`

## Requirements
- R1: After reset all control bits are 0, `irq_n` is high and `card_rst_out` follows `board_rst_out`.
- R2: A write with `wr_en` stores `wdata[3:0]` as follows: bit 0 enables re-signalling, bit 1 selects pulse style, bit 2 blocks the board reset and bit 3 forces the card reset. Bits 15:4 of the write are ignored. While `rd_en` is high, `rdata` returns the four stored bits in bits 3:0 and zeros in bits 15:4. While `rd_en` is low, `rdata` is zero.
- R3: A new source is a 0-to-1 change on any bit of `src`. It is signalled two clock edges after the first edge that samples it high. Falling or steady sources cause no signal when re-signalling is off.
- R4: In toggle style (bit 1 = 0), each signalled event inverts `irq_n`.
- R5: In pulse style (bit 1 = 1), each signalled event drives `irq_n` low for exactly PULSE_CYC cycles.
- R6: After each signalled event a hold follows: it is REARM_CYC cycles long in toggle style, and REARM_CYC cycles after the low pulse in pulse style. No event is signalled during the hold. New sources that arrive while busy are signalled once, when the hold ends.
- R7: When the hold ends with bit 0 = 1 and any `src` bit high, the block signals again. With bit 0 = 0 it returns to idle.
- R8: With bit 2 = 1, `board_rst_out` is low whatever `board_rst_req` is. With bit 2 = 0, `board_rst_out` equals `board_rst_req`.
- R9: With bit 3 = 1, `card_rst_out` is high. With bit 3 = 0, it equals `board_rst_out`.
- R10: PULSE_CYC = CLK_MHZ*PULSE_NS/1000, which gives 280 cycles at 250 MHz and 1120 ns. REARM_CYC equals PULSE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | BUS_W | Write data; only the low nibble is stored |
| rdata | output | BUS_W | Read data |
| board_rst_req | input | 1 | Board reset request, active high |
| src | input | SRC_W | Interrupt source levels, synchronous to clk |
| irq_n | output | 1 | Processor interrupt line |
| board_rst_out | output | 1 | Gated board reset, active high |
| card_rst_out | output | 1 | Memory-card reset, active high |

## Verification
The assertions take the source vector as synchronous to `clk`. They also take it that the style bit is not changed while a low pulse is in progress: the pulse-width check relies on the style holding across the whole low run. The stimulus therefore writes the control register only when the state machine has had time to return to idle. It changes `src` and the strobes one nanosecond after a rising edge and holds them for at least a full cycle.

// File: rtl/irc_pkg.sv
package irc_pkg;

    localparam int CTRL_BITS = 4;

    typedef struct packed {
        logic cf_force;
        logic rst_block;
        logic pulse_mode;
        logic resignal;
    } ctrl_t;

    typedef enum logic [1:0] {
        SIG_IDLE  = 2'd0,
        SIG_PULSE = 2'd1,
        SIG_REARM = 2'd2
    } sig_state_t;

endpackage

// File: rtl/irc_ctrl_reg.sv
module irc_ctrl_reg
    import irc_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output ctrl_t            ctrl_o
);

    localparam int PAD_W = BUS_W - CTRL_BITS;

    ctrl_t ctrl_q;
    logic  unused_upper;

    // Upper bus bits carry no data; they are folded away here.
    assign unused_upper = ^wdata[BUS_W-1:CTRL_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_BITS-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            rdata = {{PAD_W{1'b0}}, ctrl_q};
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/irc_src_edge.sv
module irc_src_edge #(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    output logic             new_evt,
    output logic             any_high
);

    logic [SRC_W-1:0] src_q;
    logic [SRC_W-1:0] src_prev;
    logic [SRC_W-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            src_prev <= '0;
        end else begin
            src_q    <= src;
            src_prev <= src_q;
        end
    end

    for (genvar i = 0; i < SRC_W; i++) begin : g_rise
        assign rise[i] = src_q[i] & ~src_prev[i];
    end

    assign new_evt  = |rise;
    assign any_high = |src_q;

endmodule

// File: rtl/irc_sig_fsm.sv
module irc_sig_fsm
    import irc_pkg::*;
#(
    parameter int PULSE_CYC = 56,
    parameter int REARM_CYC = 56
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_mode,
    input  logic       resignal,
    input  logic       new_evt,
    input  logic       any_high,
    output logic       irq_n,
    output sig_state_t state_o
);

    localparam int MAX_CYC = (PULSE_CYC > REARM_CYC) ? PULSE_CYC : REARM_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    sig_state_t     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           tog_q, tog_d;
    logic           missed_q, missed_d;
    logic           fire;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SIG_IDLE;
            cnt_q    <= '0;
            tog_q    <= 1'b1;
            missed_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            tog_q    <= tog_d;
            missed_q <= missed_d;
        end
    end

    // Next-state process
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        tog_d    = tog_q;
        missed_d = missed_q;
        fire     = 1'b0;
        unique case (state_q)
            SIG_IDLE: begin
                if (new_evt) begin
                    fire = 1'b1;
                end
            end
            SIG_PULSE: begin
                if (new_evt) begin
                    missed_d = 1'b1;
                end
                if (cnt_q == '0) begin
                    state_d = SIG_REARM;
                    cnt_d   = CW'(REARM_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            SIG_REARM: begin
                if (new_evt) begin
                    missed_d = 1'b1;
                end
                if (cnt_q == '0) begin
                    if (missed_q || new_evt || (resignal && any_high)) begin
                        fire = 1'b1;
                    end else begin
                        state_d = SIG_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = SIG_IDLE;
            end
        endcase
        if (fire) begin
            missed_d = 1'b0;
            if (pulse_mode) begin
                state_d = SIG_PULSE;
                cnt_d   = CW'(PULSE_CYC - 1);
            end else begin
                tog_d   = ~tog_q;
                state_d = SIG_REARM;
                cnt_d   = CW'(REARM_CYC - 1);
            end
        end
    end

    // Output process
    always_comb begin
        if (pulse_mode) begin
            irq_n = (state_q != SIG_PULSE);
        end else begin
            irq_n = tog_q;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/irc_rst_gate.sv
module irc_rst_gate (
    input  logic board_rst_req,
    input  logic rst_block,
    input  logic cf_force,
    output logic board_rst_out,
    output logic card_rst_out
);

    always_comb begin
        board_rst_out = board_rst_req & ~rst_block;
        card_rst_out  = cf_force | board_rst_out;
    end

endmodule

// File: rtl/irq_rst_ctrl.sv
module irq_rst_ctrl
    import irc_pkg::*;
#(
    parameter int BUS_W    = 16,
    parameter int SRC_W    = 8,
    parameter int CLK_MHZ  = 50,
    parameter int PULSE_NS = 1120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             board_rst_req,
    input  logic [SRC_W-1:0] src,
    output logic             irq_n,
    output logic             board_rst_out,
    output logic             card_rst_out
);

    localparam int RAW_CYC   = CLK_MHZ * PULSE_NS / 1000;
    localparam int PULSE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;
    localparam int REARM_CYC = PULSE_CYC;

    ctrl_t      ctrl_w;
    logic       new_evt;
    logic       any_high;
    sig_state_t fsm_state;

    irc_ctrl_reg #(.BUS_W(BUS_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wdata  (wdata),
        .rdata  (rdata),
        .ctrl_o (ctrl_w)
    );

    irc_src_edge #(.SRC_W(SRC_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .new_evt  (new_evt),
        .any_high (any_high)
    );

    irc_sig_fsm #(.PULSE_CYC(PULSE_CYC), .REARM_CYC(REARM_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_mode (ctrl_w.pulse_mode),
        .resignal   (ctrl_w.resignal),
        .new_evt    (new_evt),
        .any_high   (any_high),
        .irq_n      (irq_n),
        .state_o    (fsm_state)
    );

    irc_rst_gate u_gate (
        .board_rst_req (board_rst_req),
        .rst_block     (ctrl_w.rst_block),
        .cf_force      (ctrl_w.cf_force),
        .board_rst_out (board_rst_out),
        .card_rst_out  (card_rst_out)
    );

endmodule

// File: rtl/irq_rst_ctrl_chk.sv
module irc_checker
    import irc_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int PULSE_CYC = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [3:0]       wr_nib,
    input logic [BUS_W-1:0] rdata,
    input logic [3:0]       ctrl_bits,
    input logic             board_rst_req,
    input logic             board_rst_out,
    input logic             card_rst_out,
    input logic             irq_n,
    input sig_state_t       state
);

    localparam int LW = $clog2(PULSE_CYC + 2) + 1;

    logic [LW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (irq_n) begin
            low_run <= '0;
        end else if (low_run != {LW{1'b1}}) begin
            low_run <= low_run + 1'b1;
        end
    end

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl_bits == $past(wr_nib));

    p_read_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rdata[BUS_W-1:4] == '0);

    p_read_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    p_toggle_only_on_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(irq_n) && !ctrl_bits[1] && !$past(ctrl_bits[1])) |-> state == SIG_REARM);

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_n) && ctrl_bits[1] && $past(ctrl_bits[1])) |-> low_run == LW'(PULSE_CYC));

    p_pulse_then_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == SIG_PULSE |=> state != SIG_IDLE);

    p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_bits[2] |-> !board_rst_out);

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_bits[2] |-> board_rst_out == board_rst_req);

    p_card_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_bits[3] |-> card_rst_out);

    p_card_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_bits[3] |-> card_rst_out == board_rst_out);

endmodule

bind irq_rst_ctrl irc_checker #(.BUS_W(BUS_W), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .wr_nib        (wdata[3:0]),
    .rdata         (rdata),
    .ctrl_bits     (ctrl_w),
    .board_rst_req (board_rst_req),
    .board_rst_out (board_rst_out),
    .card_rst_out  (card_rst_out),
    .irq_n         (irq_n),
    .state         (fsm_state)
);

// File: tb/irq_rst_ctrl_test.sv
`timescale 1ns/1ps
module irq_rst_ctrl_test;

    localparam int BUS_W = 16;
    localparam int SRC_W = 4;
    localparam int MHZ   = 250;
    localparam int PNS   = 1120;
    localparam int P     = MHZ * PNS / 1000;
    localparam int R     = P;
    localparam int NONE  = 3 * P;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [BUS_W-1:0] wdata = '0;
    logic [BUS_W-1:0] rdata;
    logic             brq = 1'b0;
    logic [SRC_W-1:0] src = '0;
    logic             irq_n;
    logic             brst;
    logic             crst;

    int nvec = 0;
    int nfail = 0;

    irq_rst_ctrl #(.BUS_W(BUS_W), .SRC_W(SRC_W), .CLK_MHZ(MHZ), .PULSE_NS(PNS)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .wdata         (wdata),
        .rdata         (rdata),
        .board_rst_req (brq),
        .src           (src),
        .irq_n         (irq_n),
        .board_rst_out (brst),
        .card_rst_out  (crst)
    );

    always #2 clk = ~clk;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        nvec++;
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [BUS_W-1:0] v);
        wr_en = 1'b1;
        wdata = v;
        step();
        wr_en = 1'b0;
    endtask

    // Steps until irq_n goes low (st) and then counts the low cycles (w).
    task automatic measure(input int maxc, output int st, output int w);
        st = 0;
        w  = 0;
        while (irq_n && st < maxc) begin
            step();
            st++;
        end
        while (!irq_n && w < maxc) begin
            step();
            w++;
        end
    endtask

    initial begin
        int st;
        int w;
        logic [7:0] v;
        steps(3);
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd_en = 1'b1;
        chk("R1 rdata", int'(rdata), 0);
        rd_en = 1'b0;
        chk("R1 irq_n", int'(irq_n), 1);
        brq = 1'b1;
        #0.1;
        chk("R1 board_rst_out", int'(brst), 1);
        chk("R1 card_rst_out", int'(crst), 1);
        brq = 1'b0;
        #0.1;
        chk("R1 card_rst_out low", int'(crst), 0);

        // R2, R8, R9 exhaustive over the low byte, varying upper byte
        for (int i = 0; i < 256; i++) begin
            v   = 8'(i);
            brq = v[7];
            wr({v ^ 8'hA5, v});
            rd_en = 1'b1;
            #0.1;
            chk("R2 readback", int'(rdata), int'(v & 8'h0F));
            rd_en = 1'b0;
            #0.1;
            chk("R2 rdata idle", int'(rdata), 0);
            chk("R8 board gate", int'(brst), int'(v[7] & ~v[2]));
            chk("R9 card reset", int'(crst), int'(v[3] | (v[7] & ~v[2])));
        end
        brq = 1'b0;
        wr(16'h0000);
        steps(2 * R);

        // R3, R4 toggle style
        src = 4'b0001;
        step();
        chk("R3 latency", int'(irq_n), 1);
        step();
        chk("R4 toggle low", int'(irq_n), 0);
        steps(2 * R);
        chk("R7 no resignal", int'(irq_n), 0);
        src = 4'b0000;
        steps(R + 4);
        chk("R3 falling ignored", int'(irq_n), 0);
        src = 4'b0010;
        steps(2);
        chk("R4 toggle high", int'(irq_n), 1);
        steps(R + 4);
        src = 4'b0000;
        steps(4);

        // R7 toggle style with re-signalling
        wr(16'h0001);
        src = 4'b0001;
        steps(2);
        chk("R4 toggle retrig first", int'(irq_n), 0);
        steps(R - 1);
        chk("R6 hold in toggle", int'(irq_n), 0);
        step();
        chk("R7 toggle resignal", int'(irq_n), 1);
        src = 4'b0000;
        steps(2 * R);
        wr(16'h0002);
        steps(4);

        // R5, R10 pulse style
        src = 4'b0001;
        measure(NONE, st, w);
        chk("R3 pulse start", st, 2);
        chk("R5 R10 pulse width", w, P);
        measure(NONE, st, w);
        chk("R7 no pulse when off", st, NONE);
        src = 4'b0000;
        steps(4);

        // R7 pulse style with re-signalling
        wr(16'h0003);
        src = 4'b0001;
        measure(NONE, st, w);
        chk("R3 pulse start retrig", st, 2);
        chk("R5 pulse width retrig", w, P);
        measure(NONE, st, w);
        chk("R7 resignal gap", st, R);
        chk("R5 second width", w, P);
        src = 4'b0000;
        measure(NONE, st, w);
        chk("R7 idle after release", st, NONE);

        // R6 event during pulse is remembered
        wr(16'h0002);
        src = 4'b0001;
        steps(2);
        chk("R5 pulse low", int'(irq_n), 0);
        steps(10);
        src = 4'b0011;
        measure(NONE, st, w);
        chk("R5 remaining width", w, P - 10);
        measure(NONE, st, w);
        chk("R6 deferred start", st, R);
        chk("R6 deferred width", w, P);
        measure(NONE, st, w);
        chk("R6 single deferral", st, NONE);
        src = 4'b0000;
        measure(NONE, st, w);
        chk("R3 falling pulse ignored", st, NONE);

        report();
    end

endmodule